// File: doc/BRIEF.md
# Auxiliary Supply Selection Controller

This block decides which of three supply rails feeds the device: a primary rail and two auxiliary rails. Analog comparators outside the block deliver one "above threshold" flag per rail and a flag that says whether the primary rail is higher than the first auxiliary rail. The block turns these flags into one-hot switch enables. Every change of rail is break-before-make: all enables stay low for a programmable dead time.

Software programs the block through a small register port with three 8-bit registers. One register holds the control settings: automatic or manual switching, the manual rail choice and the dead time. One holds a per-rail choice between supervision and monitoring. One holds status. A supervised rail that drops below its threshold requests a device reset. A monitored rail that drops only raises a sticky flag and an interrupt. When no rail is valid, the block raises a brownout indication and freezes its switches.

Top module: `aux_supply_ctrl`

## Requirements
- R1: On the first clock after reset the block picks the primary rail (code 0) when `prim_gt_aux1` is 1 and auxiliary 1 (code 1) otherwise. It enables that rail after the dead time.
- R2: `sw_en` is one-hot or zero: bit 0 is primary, bit 1 is auxiliary 1, bit 2 is auxiliary 2. Status bits [1:0] hold the code of the selected rail.
- R3: Every change of rail drives `sw_en` to zero for exactly D cycles, where D is control bits [7:4]. A value of 0 acts as 1, and the reset value is 4.
- R4: In automatic mode (control bit 0 = 1, the reset value), losing the primary rail moves the selection to auxiliary 1 if it is valid and to auxiliary 2 otherwise. Losing the active auxiliary rail moves the selection to the other auxiliary rail if that rail is valid.
- R5: In automatic mode, a return from an auxiliary rail to the primary rail happens only once `prim_ok` has been 1 for 8 consecutive clocks. Any drop of `prim_ok` restarts the count.
- R6: In manual mode, the selection follows control bits [2:1] whatever the valid flags say. The value 3 is ignored and leaves the selection unchanged.
- R7: A falling valid flag on a rail whose kind bit is 1 makes `rst_req` a one-cycle pulse on the next clock. It does not set the monitor flag. Kind bits sit in register 1: bit 0 is primary, bit 1 is auxiliary 1, bit 2 is auxiliary 2.
- R8: A falling valid flag on a rail whose kind bit is 0 sets the sticky monitor flag (status bit 5) and raises `irq`. It does not raise `rst_req`.
- R9: Every rail change after start-up sets the sticky switch flag (status bit 4). Writing 1 to status bit 4 or bit 5 clears that bit.
- R10: While no rail is valid, status bit 3 (brownout) reads 1 from the next clock on. `sw_en` holds its value and no switching takes place.
- R11: Register reads are combinational: address 0 is control (reset value 0x41), address 1 is kind (reset 0), address 2 is status. Status bit 2 is 1 while a switch sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prim_ok | input | 1 | Primary rail above threshold |
| aux1_ok | input | 1 | Auxiliary 1 above threshold |
| aux2_ok | input | 1 | Auxiliary 2 above threshold |
| prim_gt_aux1 | input | 1 | Primary rail higher than auxiliary 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| sw_en | output | 3 | One-hot rail switch enables |
| rst_req | output | 1 | Reset request pulse |
| irq | output | 1 | Monitor event interrupt |

## Verification
A wrong selected-rail register shows up in the status code. It also shows up as an enable on the wrong rail, one dead time after the switch decision. A miscounting dead-time or debounce counter moves the rising edge of `sw_en` by whole cycles, so every check is timed to the exact clock. A corrupted sticky flag or kind bit appears on `irq` or `rst_req` one clock after the triggering flag falls.

// File: rtl/aux_supply_ctrl.sv
module aux_supply_ctrl #(
  parameter int DEAD_W   = 4,
  parameter int DEBOUNCE = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prim_ok,
  input  logic       aux1_ok,
  input  logic       aux2_ok,
  input  logic       prim_gt_aux1,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic [2:0] sw_en,
  output logic       rst_req,
  output logic       irq
);
  localparam int CW = $clog2(DEBOUNCE + 1);

  typedef enum logic [1:0] {ST_START, ST_DEAD, ST_RUN} st_t;

  st_t              st;
  logic [1:0]       cur, tgt;
  logic [DEAD_W-1:0] cnt, dead_eff;
  logic [CW-1:0]    pcnt;
  logic [7:0]       ctrl;
  logic [2:0]       kind, ok, ok_q, fall;
  logic             bor, swev, mon, none, go;

  assign ok       = {aux2_ok, aux1_ok, prim_ok};
  assign none     = ~|ok;
  assign fall     = ok_q & ~ok;
  assign dead_eff = (ctrl[7:4] == '0) ? DEAD_W'(1) : ctrl[7:4];
  assign go       = !none && st == ST_RUN && tgt != cur;
  assign irq      = mon;

  always_comb begin
    tgt = cur;
    if (ctrl[0]) begin
      if (cur == 2'd0) begin
        if (!prim_ok) begin
          if (aux1_ok)      tgt = 2'd1;
          else if (aux2_ok) tgt = 2'd2;
        end
      end else if (pcnt == CW'(DEBOUNCE)) tgt = 2'd0;
      else if (cur == 2'd1 && !aux1_ok && aux2_ok) tgt = 2'd2;
      else if (cur == 2'd2 && !aux2_ok && aux1_ok) tgt = 2'd1;
    end else if (ctrl[2:1] != 2'd3) begin
      tgt = ctrl[2:1];
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = ctrl;
      2'd1:    reg_rdata = {5'd0, kind};
      2'd2:    reg_rdata = {2'd0, mon, swev, bor, st != ST_RUN, cur};
      default: reg_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_START;
      cur   <= 2'd0;
      cnt   <= '0;
      sw_en <= 3'd0;
    end else if (!none) begin
      case (st)
        ST_START: begin
          cur <= prim_gt_aux1 ? 2'd0 : 2'd1;
          cnt <= dead_eff;
          st  <= ST_DEAD;
        end
        ST_DEAD: begin
          if (cnt == DEAD_W'(1)) begin
            sw_en <= 3'b001 << cur;
            st    <= ST_RUN;
          end else cnt <= cnt - 1'b1;
        end
        default: if (go) begin
          sw_en <= 3'd0;
          cur   <= tgt;
          cnt   <= dead_eff;
          st    <= ST_DEAD;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= 8'h41;
      kind    <= 3'd0;
      ok_q    <= 3'd0;
      pcnt    <= '0;
      bor     <= 1'b0;
      rst_req <= 1'b0;
      swev    <= 1'b0;
      mon     <= 1'b0;
    end else begin
      ok_q    <= ok;
      bor     <= none;
      rst_req <= |(fall & kind);
      if (!prim_ok) pcnt <= '0;
      else if (pcnt != CW'(DEBOUNCE)) pcnt <= pcnt + 1'b1;
      if (reg_wr && reg_addr == 2'd0) ctrl <= reg_wdata;
      if (reg_wr && reg_addr == 2'd1) kind <= reg_wdata[2:0];
      if (go) swev <= 1'b1;
      else if (reg_wr && reg_addr == 2'd2 && reg_wdata[4]) swev <= 1'b0;
      if (|(fall & ~kind)) mon <= 1'b1;
      else if (reg_wr && reg_addr == 2'd2 && reg_wdata[5]) mon <= 1'b0;
    end
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_en));
  p_enable_matches_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en != 3'd0) |-> (sw_en == (3'b001 << cur)));
  p_break_before_make_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_en != 3'd0) && ($past(sw_en) != 3'd0)) |-> (sw_en == $past(sw_en)));
  p_brownout_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(none) |-> $stable(sw_en));
  p_reset_needs_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(|kind));
endmodule

// File: tb/aux_supply_ctrl_test.sv
module aux_supply_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic prim_ok = 1, aux1_ok = 1, aux2_ok = 1, prim_gt_aux1 = 1;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [2:0] sw_en;
  logic rst_req, irq;
  int checks = 0, failures = 0;

  aux_supply_ctrl uut (.*);

  always #4 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic do_reset(logic gt);
    prim_ok = 1; aux1_ok = 1; aux2_ok = 1; prim_gt_aux1 = gt;
    rst_n = 0; cyc(2); rst_n = 1; cyc(5);
  endtask

  task automatic t_startup;
    logic [7:0] d;
    rst_n = 0; cyc(2);
    chk("R2 reset enables", sw_en, 0);
    chk("R7 reset rst_req", rst_req, 0);
    rd(0, d); chk("R11 ctrl reset", d, 8'h41);
    rd(1, d); chk("R11 kind reset", d, 0);
    rst_n = 1; cyc(4);
    chk("R3 startup dead time", sw_en, 0);
    cyc(1);
    chk("R1 start primary", sw_en, 3'b001);
    rd(2, d); chk("R2 status code primary", d[1:0], 0);
    do_reset(0);
    chk("R1 start aux1", sw_en, 3'b010);
    rd(2, d); chk("R2 status code aux1", d[1:0], 1);
  endtask

  task automatic t_failover;
    logic [7:0] d;
    do_reset(1);
    wr(0, 8'h21);
    prim_ok = 0; cyc(1);
    chk("R3 dead cycle 1", sw_en, 0);
    chk("R8 monitor irq", irq, 1);
    chk("R8 no rst_req", rst_req, 0);
    rd(2, d); chk("R11 busy bit", d[2], 1);
    cyc(1); chk("R3 dead cycle 2", sw_en, 0);
    cyc(1); chk("R4 to aux1", sw_en, 3'b010);
    rd(2, d); chk("R9 switch flag", d[5:4], 2'b11);
    wr(2, 8'h30);
    rd(2, d); chk("R9 w1c clear", d[5:4], 2'b00);
    chk("R8 irq cleared", irq, 0);
    aux1_ok = 0; cyc(3);
    chk("R4 to aux2", sw_en, 3'b100);
  endtask

  task automatic t_debounce;
    prim_ok = 1; cyc(6);
    prim_ok = 0; cyc(1);
    prim_ok = 1; cyc(8);
    chk("R5 still aux after 8", sw_en, 3'b100);
    cyc(1); chk("R5 leaving aux", sw_en, 0);
    cyc(2); chk("R5 back on primary", sw_en, 3'b001);
  endtask

  task automatic t_supervise;
    logic [7:0] d;
    do_reset(1);
    wr(1, 8'h01);
    prim_ok = 0; cyc(1);
    chk("R7 rst_req pulse", rst_req, 1);
    rd(2, d); chk("R7 no monitor flag", d[5], 0);
    cyc(1); chk("R7 pulse ends", rst_req, 0);
  endtask

  task automatic t_manual;
    do_reset(1);
    wr(0, 8'h44);
    cyc(1); chk("R6 manual dead", sw_en, 0);
    cyc(4); chk("R6 manual aux2", sw_en, 3'b100);
    aux2_ok = 0; cyc(3);
    chk("R6 flags ignored", sw_en, 3'b100);
    wr(0, 8'h46); cyc(6);
    chk("R6 code 3 ignored", sw_en, 3'b100);
    wr(0, 8'h02);
    cyc(1); chk("R3 zero dead acts as 1", sw_en, 0);
    cyc(1); chk("R3 zero dead enable", sw_en, 3'b010);
  endtask

  task automatic t_brownout;
    logic [7:0] d;
    do_reset(1);
    prim_ok = 0; aux1_ok = 0; aux2_ok = 0; cyc(1);
    rd(2, d); chk("R10 brownout bit", d[3], 1);
    chk("R10 enables held", sw_en, 3'b001);
    cyc(5); chk("R10 still held", sw_en, 3'b001);
    aux1_ok = 1; cyc(1);
    rd(2, d); chk("R10 brownout clears", d[3], 0);
    chk("R4 leaves primary", sw_en, 0);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_startup();
    t_failover();
    t_debounce();
    t_supervise();
    t_manual();
    t_brownout();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule